// File: doc/BRIEF.md
# Nibble memory-group instruction executor

This block carries out the memory and I/O instructions of a small 4-bit accumulator machine. The surrounding core hands it an 8-bit opcode, the 8-bit target address that an earlier select instruction latched, and the number of the currently chosen RAM bank. The block owns the machine state that these instructions touch: the 4-bit accumulator, the carry/link bit, the banked data RAM characters, the status characters, one 4-bit output port per RAM chip, and sixteen 4-bit ROM ports.

The target is never encoded in the opcode. The latched address names it instead: bits 7:6 pick one of four chips inside the current bank, bits 5:4 pick one of four registers in that chip, and bits 3:0 pick one of sixteen data characters in that register. For ROM ports, bits 7:4 pick one of sixteen ports. Subtraction is built as an addition of complements, so after a subtract the carry reads as "no borrow".

One instruction is offered per cycle on `exec_stb_i`. The block takes every strobe and never applies back-pressure, so there is no ready signal. Results show up on the clock edge that samples the strobe. On the cycle after that edge, `pc_step_o` goes high for a legal opcode and `illegal_o` goes high for an unrecognised one.

Top module: `nibble_mem_exec`

## Requirements
- R1: While `rst_i` is high at a clock edge, the accumulator, the carry, every RAM port field and every ROM port field become 0, and `pc_step_o` and `illegal_o` become 0.
- R2: Opcode 0xE0 writes the accumulator into the data character at bank `bank_i`, chip `src_addr_i[7:6]`, register `src_addr_i[5:4]`, character `src_addr_i[3:0]`. The accumulator and the carry do not change.
- R3: Opcode 0xE9 loads the selected data character into the accumulator and leaves the carry unchanged.
- R4: Opcode 0xE1 copies the accumulator into RAM port k = `bank_i`*4 + `src_addr_i[7:6]`, which is bits [4k+3:4k] of `ram_ports_o`. Every other RAM port keeps its value, and port k holds the value until the next 0xE1 that targets it.
- R5: Opcode 0xE2 copies the accumulator into ROM port j = `src_addr_i[7:4]`, which is bits [4j+3:4j] of `rom_ports_o`. Port j holds the value until the next 0xE2 that targets port j. Writes to other ports do not change it.
- R6: Opcode 0xEA loads ROM port j = `src_addr_i[7:4]` into the accumulator and leaves the carry unchanged.
- R7: Opcode 0xEB forms the sum of the selected data character, the accumulator and the carry. The accumulator takes the low 4 bits of the sum. The carry becomes 1 if the sum is greater than 15, and 0 otherwise.
- R8: Opcode 0xE8 forms accumulator + (15 − character) + (1 − carry). The accumulator takes the low 4 bits. The carry becomes 1 if the sum is greater than 15, which means no borrow, and 0 if there was a borrow.
- R9: Opcode 0xE4+n (n = 0..3) writes the accumulator into status character n of bank `bank_i`, chip `src_addr_i[7:6]`, register `src_addr_i[5:4]`. Opcode 0xEC+n loads that status character into the accumulator and leaves the carry unchanged. Status characters are storage separate from the data characters.
- R10: An opcode whose upper nibble is not 0xE, or the opcode 0xE3, changes no state. It raises `illegal_o` for the one cycle after the strobe and does not raise `pc_step_o`.
- R11: Every accepted legal opcode raises `pc_step_o` for the one cycle after the strobe. A cycle without a strobe changes no state and raises neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| exec_stb_i | input | 1 | Execute one instruction this cycle |
| opcode_i | input | 8 | Instruction code |
| src_addr_i | input | 8 | Latched chip/register/character or ROM port address |
| bank_i | input | BANK_W (3) | Current RAM bank |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry/link bit |
| pc_step_o | output | 1 | One-cycle program-counter advance pulse |
| illegal_o | output | 1 | One-cycle unrecognised-opcode pulse |
| ram_ports_o | output | 4*BANKS*4 (128) | RAM chip output ports, port k in bits [4k+3:4k] |
| rom_ports_o | output | 64 | ROM ports, port j in bits [4j+3:4j] |

## Verification
A corrupted data or status character stays hidden until an instruction reads it. The fault then shows up in `acc_o`, and after an add or a subtract also in `carry_o`, one cycle after that read strobe. A corrupted port register shows at once in the flattened port buses. A corrupted accumulator shows directly, and it also spreads into every later write, so it shows up again as wrong port contents or wrong read-backs. The bench therefore compares the accumulator, the carry, both port buses and both pulses after every single instruction.

// File: rtl/nme_pkg.sv
package nme_pkg;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned CHIPS    = 4;
  localparam int unsigned ROM_N    = 16;
  localparam int unsigned STAT_N   = 4;
  localparam logic [3:0]  GROUP_HI = 4'hE;

  typedef enum logic [3:0] {
    K_NONE, K_WRM, K_WMP, K_WRR, K_STW,
    K_SUB, K_RDM, K_RDR, K_ADD, K_STR
  } kind_e;
endpackage

// File: rtl/nme_decode.sv
module nme_decode
  import nme_pkg::*;
(
  input  logic [7:0] opcode_i,
  output kind_e      kind_o,
  output logic [1:0] stat_sel_o,
  output logic       bad_o
);
  assign stat_sel_o = opcode_i[1:0];

  always_comb begin
    kind_o = K_NONE;
    bad_o  = 1'b0;
    if (opcode_i[7:4] != GROUP_HI) begin
      bad_o = 1'b1;
    end else begin
      unique case (opcode_i[3:0])
        4'h0:                      kind_o = K_WRM;
        4'h1:                      kind_o = K_WMP;
        4'h2:                      kind_o = K_WRR;
        4'h3:                      bad_o  = 1'b1;
        4'h4, 4'h5, 4'h6, 4'h7:    kind_o = K_STW;
        4'h8:                      kind_o = K_SUB;
        4'h9:                      kind_o = K_RDM;
        4'hA:                      kind_o = K_RDR;
        4'hB:                      kind_o = K_ADD;
        default:                   kind_o = K_STR;
      endcase
    end
  end

  always_comb begin
    assert (bad_o == (kind_o == K_NONE))
      else $error("a_r10_decode_exclusive");
  end
endmodule

// File: rtl/nme_alu.sv
module nme_alu
  import nme_pkg::*;
(
  input  logic [NIB_W-1:0] acc_i,
  input  logic [NIB_W-1:0] mem_i,
  input  logic             cy_i,
  input  logic             sub_i,
  output logic [NIB_W-1:0] sum_o,
  output logic             cy_o
);
  logic [NIB_W-1:0] operand;
  logic             cin;
  logic [NIB_W:0]   total;

  always_comb begin
    operand = sub_i ? ~mem_i : mem_i;
    cin     = sub_i ? ~cy_i  : cy_i;
    total   = {1'b0, acc_i} + {1'b0, operand} + {{NIB_W{1'b0}}, cin};
    sum_o   = total[NIB_W-1:0];
    cy_o    = total[NIB_W];
  end
endmodule

// File: rtl/nme_store.sv
module nme_store
  import nme_pkg::*;
#(
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [7:0]        addr_i,
  input  logic              data_we_i,
  input  logic              stat_we_i,
  input  logic [1:0]        stat_sel_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [NIB_W-1:0]  data_rd_o,
  output logic [NIB_W-1:0]  stat_rd_o
);
  localparam int unsigned DATA_AW    = BANK_W + 8;
  localparam int unsigned STAT_AW    = BANK_W + 4 + $clog2(STAT_N);
  localparam int unsigned DATA_DEPTH = 1 << DATA_AW;
  localparam int unsigned STAT_DEPTH = 1 << STAT_AW;

  logic [NIB_W-1:0]   dmem [DATA_DEPTH];
  logic [NIB_W-1:0]   smem [STAT_DEPTH];
  logic [DATA_AW-1:0] d_idx;
  logic [STAT_AW-1:0] s_idx;

  assign d_idx = {bank_i, addr_i};
  assign s_idx = {bank_i, addr_i[7:4], stat_sel_i};

  always_ff @(posedge clk_i) begin
    if (data_we_i) dmem[d_idx] <= wdata_i;
    if (stat_we_i) smem[s_idx] <= wdata_i;
  end

  assign data_rd_o = dmem[d_idx];
  assign stat_rd_o = smem[s_idx];

  // R2: a written character reads back while the address is held
  a_r2_data_readback: assert property (@(posedge clk_i) disable iff (rst_i)
    data_we_i |=> (!($stable(addr_i) && $stable(bank_i)) || data_rd_o == $past(wdata_i)));

  // R9: a written status character reads back while its selection is held
  a_r9_stat_readback: assert property (@(posedge clk_i) disable iff (rst_i)
    stat_we_i |=> (!($stable(addr_i) && $stable(bank_i) && $stable(stat_sel_i))
                   || stat_rd_o == $past(wdata_i)));
endmodule

// File: rtl/nme_ports.sv
module nme_ports
  import nme_pkg::*;
#(
  parameter  int unsigned BANK_W = 3,
  localparam int unsigned RAM_N  = CHIPS << BANK_W
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     ram_we_i,
  input  logic [BANK_W+1:0]        ram_sel_i,
  input  logic                     rom_we_i,
  input  logic [3:0]               rom_sel_i,
  input  logic [NIB_W-1:0]         wdata_i,
  output logic [RAM_N*NIB_W-1:0]   ram_ports_o,
  output logic [ROM_N*NIB_W-1:0]   rom_ports_o,
  output logic [NIB_W-1:0]         rom_rd_o
);
  for (genvar k = 0; k < RAM_N; k++) begin : g_ram
    always_ff @(posedge clk_i) begin
      if (rst_i)
        ram_ports_o[k*NIB_W +: NIB_W] <= '0;
      else if (ram_we_i && ram_sel_i == k[BANK_W+1:0])
        ram_ports_o[k*NIB_W +: NIB_W] <= wdata_i;
    end

    // R4: a RAM port moves only when it is the write target
    a_r4_ram_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !(ram_we_i && ram_sel_i == k[BANK_W+1:0]) |=> $stable(ram_ports_o[k*NIB_W +: NIB_W]));
  end

  for (genvar j = 0; j < ROM_N; j++) begin : g_rom
    always_ff @(posedge clk_i) begin
      if (rst_i)
        rom_ports_o[j*NIB_W +: NIB_W] <= '0;
      else if (rom_we_i && rom_sel_i == j[3:0])
        rom_ports_o[j*NIB_W +: NIB_W] <= wdata_i;
    end

    // R5: a ROM port holds until written again
    a_r5_rom_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !(rom_we_i && rom_sel_i == j[3:0]) |=> $stable(rom_ports_o[j*NIB_W +: NIB_W]));
  end

  assign rom_rd_o = rom_ports_o[rom_sel_i*NIB_W +: NIB_W];
endmodule

// File: rtl/nibble_mem_exec.sv
module nibble_mem_exec
  import nme_pkg::*;
#(
  parameter  int unsigned BANKS  = 8,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned RAM_N  = CHIPS << BANK_W
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   exec_stb_i,
  input  logic [7:0]             opcode_i,
  input  logic [7:0]             src_addr_i,
  input  logic [BANK_W-1:0]      bank_i,
  output logic [NIB_W-1:0]       acc_o,
  output logic                   carry_o,
  output logic                   pc_step_o,
  output logic                   illegal_o,
  output logic [RAM_N*NIB_W-1:0] ram_ports_o,
  output logic [ROM_N*NIB_W-1:0] rom_ports_o
);
  kind_e            kind;
  logic [1:0]       stat_sel;
  logic             bad;
  logic             go;
  logic [NIB_W-1:0] data_rd, stat_rd, rom_rd, alu_sum;
  logic             alu_cy;

  nme_decode u_dec (
    .opcode_i  (opcode_i),
    .kind_o    (kind),
    .stat_sel_o(stat_sel),
    .bad_o     (bad)
  );

  assign go = exec_stb_i && !bad;

  nme_store #(.BANK_W(BANK_W)) u_store (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .bank_i    (bank_i),
    .addr_i    (src_addr_i),
    .data_we_i (go && kind == K_WRM),
    .stat_we_i (go && kind == K_STW),
    .stat_sel_i(stat_sel),
    .wdata_i   (acc_o),
    .data_rd_o (data_rd),
    .stat_rd_o (stat_rd)
  );

  nme_ports #(.BANK_W(BANK_W)) u_ports (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ram_we_i   (go && kind == K_WMP),
    .ram_sel_i  ({bank_i, src_addr_i[7:6]}),
    .rom_we_i   (go && kind == K_WRR),
    .rom_sel_i  (src_addr_i[7:4]),
    .wdata_i    (acc_o),
    .ram_ports_o(ram_ports_o),
    .rom_ports_o(rom_ports_o),
    .rom_rd_o   (rom_rd)
  );

  nme_alu u_alu (
    .acc_i(acc_o),
    .mem_i(data_rd),
    .cy_i (carry_o),
    .sub_i(kind == K_SUB),
    .sum_o(alu_sum),
    .cy_o (alu_cy)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_o     <= '0;
      carry_o   <= 1'b0;
      pc_step_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      pc_step_o <= go;
      illegal_o <= exec_stb_i && bad;
      if (go) begin
        case (kind)
          K_RDM:        acc_o <= data_rd;
          K_RDR:        acc_o <= rom_rd;
          K_STR:        acc_o <= stat_rd;
          K_ADD, K_SUB: {carry_o, acc_o} <= {alu_cy, alu_sum};
          default:      ;
        endcase
      end
    end
  end

  // R10: an unrecognised opcode leaves accumulator and carry alone
  a_r10_illegal_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (exec_stb_i && bad) |=> ($stable(acc_o) && $stable(carry_o) && illegal_o && !pc_step_o));

  // R2: write-type instructions keep accumulator and carry
  a_r2_write_keeps_acc: assert property (@(posedge clk_i) disable iff (rst_i)
    (go && (kind == K_WRM || kind == K_WMP || kind == K_WRR || kind == K_STW))
    |=> ($stable(acc_o) && $stable(carry_o)));

  // R3: loads keep the carry
  a_r3_load_keeps_carry: assert property (@(posedge clk_i) disable iff (rst_i)
    (go && (kind == K_RDM || kind == K_RDR || kind == K_STR)) |=> $stable(carry_o));

  // R11: no strobe, no change and no pulse
  a_r11_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !exec_stb_i |=> (!pc_step_o && !illegal_o && $stable(acc_o) && $stable(carry_o)));

  // R11: the two pulses never coincide
  a_r11_pulse_excl: assert property (@(posedge clk_i) disable iff (rst_i)
    !(pc_step_o && illegal_o));
endmodule

// File: tb/nibble_mem_exec_bench.sv
module nibble_mem_exec_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         stb;
  logic [7:0]   op, addr;
  logic [2:0]   bank;
  logic [3:0]   acc;
  logic         cy, pc_step, ill;
  logic [127:0] ramp;
  logic [63:0]  romp;

  always #10 clk = ~clk;

  nibble_mem_exec u_nibble_mem_exec (
    .clk_i(clk), .rst_i(rst), .exec_stb_i(stb), .opcode_i(op),
    .src_addr_i(addr), .bank_i(bank), .acc_o(acc), .carry_o(cy),
    .pc_step_o(pc_step), .illegal_o(ill), .ram_ports_o(ramp), .rom_ports_o(romp)
  );

  typedef struct {
    logic [3:0]   acc;
    logic         cy;
    logic         pc;
    logic         ill;
    logic [127:0] ramp;
    logic [63:0]  romp;
    string        tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [3:0] m_mem [2048];
  logic [3:0] m_st  [512];
  logic [3:0] m_ramp [32];
  logic [3:0] m_romp [16];
  logic [3:0] m_acc;
  logic       m_cy;

  function automatic logic [127:0] flat_ram();
    logic [127:0] v;
    for (int k = 0; k < 32; k++) v[k*4 +: 4] = m_ramp[k];
    return v;
  endfunction

  function automatic logic [63:0] flat_rom();
    logic [63:0] v;
    for (int j = 0; j < 16; j++) v[j*4 +: 4] = m_romp[j];
    return v;
  endfunction

  function automatic string tag_of(input logic [7:0] o);
    if (o[7:4] != 4'hE || o[3:0] == 4'h3) return "R10";
    case (o[3:0])
      4'h0: return "R2";
      4'h1: return "R4";
      4'h2: return "R5";
      4'h8: return "R8";
      4'h9: return "R3";
      4'hA: return "R6";
      4'hB: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_acc = 0; m_cy = 0;
    for (int k = 0; k < 32; k++) m_ramp[k] = 0;
    for (int j = 0; j < 16; j++) m_romp[j] = 0;
  endtask

  // driver: called at a falling edge; pushes expected post-state, strobes one cycle
  task automatic run(input logic [7:0] o, input logic [7:0] a, input logic [2:0] b);
    item_t it;
    logic [4:0] s;
    logic illegal;
    illegal = (o[7:4] != 4'hE) || (o[3:0] == 4'h3);
    if (!illegal) begin
      case (o[3:0])
        4'h0: m_mem[{b, a}] = m_acc;
        4'h1: m_ramp[{b, a[7:6]}] = m_acc;
        4'h2: m_romp[a[7:4]] = m_acc;
        4'h4, 4'h5, 4'h6, 4'h7: m_st[{b, a[7:4], o[1:0]}] = m_acc;
        4'h8: begin
          s = 5'(m_acc) + 5'(4'hF - m_mem[{b, a}]) + 5'(!m_cy);
          m_acc = s[3:0]; m_cy = s[4];
        end
        4'h9: m_acc = m_mem[{b, a}];
        4'hA: m_acc = m_romp[a[7:4]];
        4'hB: begin
          s = 5'(m_acc) + 5'(m_mem[{b, a}]) + 5'(m_cy);
          m_acc = s[3:0]; m_cy = s[4];
        end
        default: m_acc = m_st[{b, a[7:4], o[1:0]}];
      endcase
    end
    it.acc = m_acc; it.cy = m_cy; it.pc = !illegal; it.ill = illegal;
    it.ramp = flat_ram(); it.romp = flat_rom(); it.tag = tag_of(o);
    q.push_back(it);
    op = o; addr = a; bank = b; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per result pulse
  always @(negedge clk) begin
    if (!rst && (pc_step || ill)) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R11 unexpected pulse actual=%b%b expected=00", pc_step, ill);
      end else begin
        item_t e;
        e = q.pop_front();
        if (acc !== e.acc || cy !== e.cy || pc_step !== e.pc || ill !== e.ill ||
            ramp !== e.ramp || romp !== e.romp) begin
          bad++;
          $display("FAIL %s actual acc=%h cy=%b pc=%b ill=%b ramp=%h romp=%h expected acc=%h cy=%b pc=%b ill=%b ramp=%h romp=%h",
                   e.tag, acc, cy, pc_step, ill, ramp, romp,
                   e.acc, e.cy, e.pc, e.ill, e.ramp, e.romp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [7:0] ADDRS [5] = '{8'h00, 8'h5A, 8'hC3, 8'hFF, 8'h37};
  localparam logic [2:0] BNKS  [3] = '{3'd0, 3'd3, 3'd7};

  initial begin
    logic [15:0] lfsr;
    logic [3:0]  keep;
    rst = 1'b1; stb = 1'b0; op = 0; addr = 0; bank = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 acc", {4'h0, acc}, 8'h00);
    chk("R1 carry", {7'h0, cy}, 8'h00);
    chk("R1 ports", {7'h0, (ramp == 0 && romp == 0)}, 8'h01);
    chk("R1 pulses", {6'h0, pc_step, ill}, 8'h00);

    // R8 hand-worked subtraction: 0 - 0 with no borrow in, then with borrow in
    run(8'hE0, 8'h00, 3'd0);
    run(8'hE8, 8'h00, 3'd0);
    chk("R8 no-borrow acc", {4'h0, acc}, 8'h00);
    chk("R8 no-borrow carry", {7'h0, cy}, 8'h01);
    run(8'hE8, 8'h00, 3'd0);
    chk("R8 borrow acc", {4'h0, acc}, 8'h0F);
    chk("R8 borrow carry", {7'h0, cy}, 8'h00);
    // R7 hand-worked overflow: F + F + 0 = 0x1E, then F + E + 1 = 0x1E
    run(8'hE0, 8'h11, 3'd2);
    run(8'hEB, 8'h11, 3'd2);
    chk("R7 overflow acc", {4'h0, acc}, 8'h0E);
    chk("R7 overflow carry", {7'h0, cy}, 8'h01);
    run(8'hEB, 8'h11, 3'd2);
    chk("R7 carry-in acc", {4'h0, acc}, 8'h0E);

    // R4/R5 targeted port writes, R6 read back
    run(8'hE1, 8'h80, 3'd5);          // RAM port 5*4+2 = 22
    chk("R4 port22", {4'h0, ramp[22*4 +: 4]}, 8'h0E);
    run(8'hE2, 8'h90, 3'd0);          // ROM port 9
    chk("R5 port9", {4'h0, romp[9*4 +: 4]}, 8'h0E);
    run(8'hEA, 8'h30, 3'd0);          // ROM port 3 is still 0
    chk("R6 read zero port", {4'h0, acc}, 8'h00);
    run(8'hEA, 8'h9F, 3'd1);          // low address bits do not matter
    chk("R6 read port9", {4'h0, acc}, 8'h0E);

    // R10 illegal codes
    keep = acc;
    run(8'hE3, 8'h00, 3'd0);
    chk("R10 E3 acc", {4'h0, acc}, {4'h0, keep});
    run(8'h3C, 8'h00, 3'd0);
    run(8'hF0, 8'h00, 3'd0);

    // R11 idle cycles
    repeat (4) @(negedge clk);
    chk("R11 idle pulses", {6'h0, pc_step, ill}, 8'h00);
    chk("R11 idle acc", {4'h0, acc}, {4'h0, keep});

    // prefill the address pool (data and all status characters)
    for (int bi = 0; bi < 3; bi++)
      for (int ai = 0; ai < 5; ai++) begin
        run(8'hEB, 8'h11, 3'd2);
        run(8'hE0, ADDRS[ai], BNKS[bi]);
        for (int n = 0; n < 4; n++) begin
          run(8'hE8, 8'h11, 3'd2);
          run(8'hE4 + 8'(n), ADDRS[ai], BNKS[bi]);
        end
      end

    // R9 status is separate from data: write status, read data at same place
    run(8'hE9, 8'hC3, 3'd7);
    keep = acc;
    run(8'hEB, 8'h11, 3'd2);
    run(8'hE5, 8'hC3, 3'd7);
    run(8'hE9, 8'hC3, 3'd7);
    chk("R9 data untouched", {4'h0, acc}, {4'h0, keep});

    // mixed stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] o;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[3:0])
        4'h3:    o = lfsr[8] ? 8'hE3 : 8'h7B;
        4'h4:    o = 8'hE4 + 8'(lfsr[6:5]);
        4'hC:    o = 8'hEC + 8'(lfsr[6:5]);
        default: o = {4'hE, lfsr[3:0]};
      endcase
      run(o, ADDRS[lfsr[11:9] % 5], BNKS[lfsr[14:13] % 3]);
    end

    // R1 mid-run reset clears ports, accumulator and carry
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1 rerun acc/carry", {3'h0, cy, acc}, 8'h00);
    chk("R1 rerun ports", {7'h0, (ramp == 0 && romp == 0)}, 8'h01);

    repeat (2) @(negedge clk);
    chk("R11 queue drained", 8'(q.size()), 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule